// File: doc/BRIEF.md
# Active-Matrix LCD Timing Generator

This block produces the synchronisation and pixel-clock signals for an active-matrix LCD panel. It runs on the system clock. It advances one step on each cycle in which the pixel-rate enable `pix_ce` is high, and that step is called a pixel tick below. Each line period is laid out in a fixed order:

1. a line-sync pulse,
2. a blank lead-in,
3. the active pixels,
4. a blank tail.

A frame is a sequence of these line periods. Frame sync is held for a programmable number of whole line periods. A programmable number of blank lines follows it, and then the active lines.

During each active pixel the block asserts an output enable. It gates one pixel-clock pulse out for each pixel and drives the 8-bit pixel value onto the panel bus. A fetch request tells the pixel source to present the next value one tick ahead. When the enable input is low, the block is idle with every output inactive. The timing fields are captured only when a frame begins.

Top module: `lcd_tgen`

## Requirements
- R1: While idle, both syncs sit at their inactive level and `oe`, `pclk`, `pix_req` and `pix_data` are 0. A pixel tick that sees `enable` low makes the block idle. A pixel tick that sees `enable` high while idle starts a frame, and the first line period begins on that tick.
- R2: A polarity bit of 0 makes its sync active high, and a bit of 1 makes it active low. This applies to `vs_pol` for `vsync` and to `hs_pol` for `hsync`. While idle, the inactive level follows the live polarity inputs.
- R3: Each line period opens with `hsync` active for `hs_width_m1`+1 pixel ticks. This holds in every line of the frame, blank lines included.
- R4: After line sync, there are `bol_wait_m1`+1 blank ticks. Then come `ppl_m1`+1 active ticks, then `eol_wait_m1`+1 blank ticks, and then the next line sync. In active lines, `oe` is high exactly during the active ticks.
- R5: `vsync` is active for the first `vs_width_m1`+1 whole line periods of a frame, starting on the same tick as the first line sync.
- R6: After frame sync come `frame_wait` blank line periods (0 to 255, used as is). Then come `lines_m1`+1 active lines, after which the next frame begins with frame sync.
- R7: `pclk` is high exactly in the cycles where `oe` and `pix_ce` are both high, so each active pixel gets one pulse.
- R8: `pix_req` is high in the pixel-tick cycle just before each active pixel. The value on `pix_in` in that cycle is captured and shown on `pix_data` for that pixel. `pix_data` is 0 whenever `oe` is low.
- R9: The timing fields and polarity bits are captured when a frame starts. Changes made during a frame take effect from the next frame.
- R10: Outputs other than `pclk` and `pix_req` change only on clock edges where `pix_ce` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_ce | input | 1 | Pixel-rate clock enable |
| enable | input | 1 | Run (1) or idle (0) |
| vs_pol | input | 1 | Frame-sync polarity, 1 = active low |
| hs_pol | input | 1 | Line-sync polarity, 1 = active low |
| vs_width_m1 | input | 6 | Frame-sync width in line periods, minus one |
| hs_width_m1 | input | 6 | Line-sync width in pixel ticks, minus one |
| frame_wait | input | 8 | Blank line periods after frame sync |
| bol_wait_m1 | input | 8 | Blank ticks after line sync, minus one |
| eol_wait_m1 | input | 8 | Blank ticks after the last pixel, minus one |
| ppl_m1 | input | 10 | Active pixels per line, minus one |
| lines_m1 | input | 10 | Active lines per frame, minus one |
| pix_in | input | 8 | Next pixel value from the source |
| pix_req | output | 1 | Fetch request for the next pixel |
| vsync | output | 1 | Frame sync |
| hsync | output | 1 | Line sync |
| oe | output | 1 | Output enable, high during active pixels |
| pclk | output | 1 | Gated pixel clock pulse |
| pix_data | output | 8 | Panel pixel bus |

## Verification
The bench targets the extreme field values:

- The longest line (64-tick sync, 256-tick waits, 1024 pixels), where a counter that is too narrow or an off-by-one in the minus-one encoding would truncate or extend a phase.
- A 255-line frame wait, and a zero frame wait, where a design that cannot skip the blank-line phase would insert a stray line.
- A 64-line frame sync, where `vsync` would end early or late.

It rewrites the fields in the middle of a frame. A design that does not latch its configuration would bend the current frame. It also drops `enable` mid-line. A design that only stops at a frame boundary would keep driving `oe` and `pclk`. Random configurations under several `pix_ce` rates expose any output that moves between pixel ticks, or a fetch request that is not exactly one tick ahead of its pixel.

// File: rtl/lcd_tgen_pkg.sv
`timescale 1ns/1ps
// Shared widths and types for the LCD timing generator.
package lcd_tgen_pkg;
    localparam int SYNC_W = 6;   // sync width fields
    localparam int WAIT_W = 8;   // line and frame wait fields
    localparam int CNT_W  = 10;  // pixel/line counters, widest field

    typedef enum logic [1:0] {HP_SYNC, HP_BOL, HP_ACT, HP_EOL} hphase_t;
    typedef enum logic [1:0] {VP_SYNC, VP_WAIT, VP_ACT} vphase_t;

    // Timing set captured at frame start.
    typedef struct packed {
        logic              vs_pol;
        logic              hs_pol;
        logic [SYNC_W-1:0] vs_w_m1;
        logic [SYNC_W-1:0] hs_w_m1;
        logic [WAIT_W-1:0] fwait;
        logic [WAIT_W-1:0] bol_m1;
        logic [WAIT_W-1:0] eol_m1;
        logic [CNT_W-1:0]  ppl_m1;
        logic [CNT_W-1:0]  lines_m1;
    } tcfg_t;
endpackage

// File: rtl/lcd_tgen_hseq.sv
`timescale 1ns/1ps
// Horizontal sequencer: walks one line period through sync, lead-in,
// active pixels and tail, one pixel tick per step.
// Assumes the limit inputs only change on a restart.
module lcd_tgen_hseq
    import lcd_tgen_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic                 step,
    input  logic [SYNC_W-1:0]    hs_w_m1,
    input  logic [WAIT_W-1:0]    bol_m1,
    input  logic [WAIT_W-1:0]    eol_m1,
    input  logic [CNT_W-1:0]     ppl_m1,
    output hphase_t              phase,
    output logic                 line_last,
    output logic                 next_act
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             at_lim;
    hphase_t          phase_nx;

    // Select the terminal count and successor of the current phase.
    always_comb begin
        case (phase)
            HP_SYNC: begin limit = CNT_W'(hs_w_m1); phase_nx = HP_BOL;  end
            HP_BOL:  begin limit = CNT_W'(bol_m1);  phase_nx = HP_ACT;  end
            HP_ACT:  begin limit = ppl_m1;          phase_nx = HP_EOL;  end
            default: begin limit = CNT_W'(eol_m1);  phase_nx = HP_SYNC; end
        endcase
    end

    assign at_lim    = (cnt == limit);
    assign line_last = (phase == HP_EOL) && at_lim;
    assign next_act  = ((phase == HP_BOL) && at_lim) ||
                       ((phase == HP_ACT) && !at_lim);

    // Advance the phase counter on each pixel tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= HP_SYNC;
            cnt   <= '0;
        end else if (restart) begin
            phase <= HP_SYNC;
            cnt   <= '0;
        end else if (step) begin
            if (at_lim) begin
                phase <= phase_nx;
                cnt   <= '0;
            end else begin
                cnt <= cnt + ONE;
            end
        end
    end

    AST_HCNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= limit) else $error("hseq counter past limit"); // R4
    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !(step || restart) |=> $stable(cnt) && $stable(phase)) else $error("hseq moved without tick"); // R10
endmodule

// File: rtl/lcd_tgen_vseq.sv
`timescale 1ns/1ps
// Vertical sequencer: counts line periods through frame sync, blank
// lines and active lines. Steps once per completed line period.
// Assumes the limit inputs only change on a restart.
module lcd_tgen_vseq
    import lcd_tgen_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic                 line_step,
    input  logic [SYNC_W-1:0]    vs_w_m1,
    input  logic [WAIT_W-1:0]    fwait,
    input  logic [CNT_W-1:0]     lines_m1,
    output vphase_t              phase,
    output logic                 frame_last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             at_lim;
    vphase_t          phase_nx;

    // Terminal count per phase; the blank phase is skipped when empty.
    always_comb begin
        case (phase)
            VP_SYNC: begin
                limit    = CNT_W'(vs_w_m1);
                phase_nx = (fwait == '0) ? VP_ACT : VP_WAIT;
            end
            VP_WAIT: begin
                limit    = CNT_W'(fwait - WAIT_W'(1));
                phase_nx = VP_ACT;
            end
            default: begin
                limit    = lines_m1;
                phase_nx = VP_SYNC;
            end
        endcase
    end

    assign at_lim     = (cnt == limit);
    assign frame_last = (phase == VP_ACT) && at_lim;

    // Advance the line counter at the end of each line period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= VP_SYNC;
            cnt   <= '0;
        end else if (restart) begin
            phase <= VP_SYNC;
            cnt   <= '0;
        end else if (line_step) begin
            if (at_lim) begin
                phase <= phase_nx;
                cnt   <= '0;
            end else begin
                cnt <= cnt + ONE;
            end
        end
    end

    AST_VCNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= limit) else $error("vseq counter past limit"); // R6
    AST_VHOLD_BETWEEN_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_step || restart) |=> $stable(cnt)) else $error("vseq moved mid-line"); // R10
endmodule

// File: rtl/lcd_tgen_out.sv
`timescale 1ns/1ps
// Output stage: applies sync polarity, gates the pixel clock and holds
// the fetched pixel for the panel bus. Idle levels use live polarity.
module lcd_tgen_out
    import lcd_tgen_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              pix_ce,
    input  logic              vs_pol_live,
    input  logic              hs_pol_live,
    input  logic              vs_pol_q,
    input  logic              hs_pol_q,
    input  vphase_t           vphase,
    input  hphase_t           hphase,
    input  logic              fetch,
    input  logic [DATA_W-1:0] pix_in,
    output logic              vsync,
    output logic              hsync,
    output logic              oe,
    output logic              pclk,
    output logic [DATA_W-1:0] pix_data
);
    logic              vs_act;
    logic              hs_act;
    logic [DATA_W-1:0] data_q;

    // Active-level decode and polarity application.
    always_comb begin
        vs_act = busy && (vphase == VP_SYNC);
        hs_act = busy && (hphase == HP_SYNC);
        oe     = busy && (vphase == VP_ACT) && (hphase == HP_ACT);
        vsync  = busy ? (vs_act ^ vs_pol_q) : vs_pol_live;
        hsync  = busy ? (hs_act ^ hs_pol_q) : hs_pol_live;
        pclk   = oe && pix_ce;
    end

    // Capture the source word on each fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else if (fetch) data_q <= pix_in;
    end

    assign pix_data = oe ? data_q : '0;

    AST_FETCH_LEADS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |=> oe) else $error("fetch not followed by pixel"); // R8
    AST_OE_ENTRY_FETCHED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(fetch)) else $error("pixel without fetch"); // R8
endmodule

// File: rtl/lcd_tgen.sv
`timescale 1ns/1ps
// LCD timing generator top: captures the timing set at frame start,
// sequences lines and frames on pixel ticks and drives the panel pins.
// Assumes pix_ce is a single-cycle enable at pixel rate.
module lcd_tgen
    import lcd_tgen_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_ce,
    input  logic              enable,
    input  logic              vs_pol,
    input  logic              hs_pol,
    input  logic [SYNC_W-1:0] vs_width_m1,
    input  logic [SYNC_W-1:0] hs_width_m1,
    input  logic [WAIT_W-1:0] frame_wait,
    input  logic [WAIT_W-1:0] bol_wait_m1,
    input  logic [WAIT_W-1:0] eol_wait_m1,
    input  logic [CNT_W-1:0]  ppl_m1,
    input  logic [CNT_W-1:0]  lines_m1,
    input  logic [DATA_W-1:0] pix_in,
    output logic              pix_req,
    output logic              vsync,
    output logic              hsync,
    output logic              oe,
    output logic              pclk,
    output logic [DATA_W-1:0] pix_data
);
    tcfg_t   cfg_live;
    tcfg_t   cfg_q;
    logic    busy;
    logic    tick_run;
    logic    frame_end;
    logic    restart;
    logic    step;
    hphase_t hphase;
    vphase_t vphase;
    logic    line_last;
    logic    next_act;
    logic    frame_last;

    assign cfg_live = '{vs_pol: vs_pol, hs_pol: hs_pol,
                        vs_w_m1: vs_width_m1, hs_w_m1: hs_width_m1,
                        fwait: frame_wait, bol_m1: bol_wait_m1,
                        eol_m1: eol_wait_m1, ppl_m1: ppl_m1,
                        lines_m1: lines_m1};

    // Tick qualification: start, wrap or advance.
    always_comb begin
        tick_run  = pix_ce && enable;
        frame_end = busy && line_last && frame_last;
        restart   = tick_run && (!busy || frame_end);
        step      = tick_run && busy && !frame_end;
        pix_req   = step && (vphase == VP_ACT) && next_act;
    end

    // Run state and frame-start capture of the timing set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cfg_q <= '0;
        end else if (pix_ce) begin
            if (!enable) begin
                busy <= 1'b0;
            end else if (restart) begin
                busy  <= 1'b1;
                cfg_q <= cfg_live;
            end
        end
    end

    lcd_tgen_hseq u_hseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .step      (step),
        .hs_w_m1   (cfg_q.hs_w_m1),
        .bol_m1    (cfg_q.bol_m1),
        .eol_m1    (cfg_q.eol_m1),
        .ppl_m1    (cfg_q.ppl_m1),
        .phase     (hphase),
        .line_last (line_last),
        .next_act  (next_act)
    );

    lcd_tgen_vseq u_vseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .line_step  (step && line_last),
        .vs_w_m1    (cfg_q.vs_w_m1),
        .fwait      (cfg_q.fwait),
        .lines_m1   (cfg_q.lines_m1),
        .phase      (vphase),
        .frame_last (frame_last)
    );

    lcd_tgen_out #(.DATA_W(DATA_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy        (busy),
        .pix_ce      (pix_ce),
        .vs_pol_live (vs_pol),
        .hs_pol_live (hs_pol),
        .vs_pol_q    (cfg_q.vs_pol),
        .hs_pol_q    (cfg_q.hs_pol),
        .vphase      (vphase),
        .hphase      (hphase),
        .fetch       (pix_req),
        .pix_in      (pix_in),
        .vsync       (vsync),
        .hsync       (hsync),
        .oe          (oe),
        .pclk        (pclk),
        .pix_data    (pix_data)
    );

    AST_IDLE_AFTER_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ce && !enable) |=> (!oe && !pclk && !busy)) else $error("not idle after disable"); // R1
    AST_FRAME_OPENS_SYNCED: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (vsync == !cfg_q.vs_pol) && (hsync == !cfg_q.hs_pol)) else $error("frame start without syncs"); // R5
    AST_CFG_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !restart) |=> $stable(cfg_q)) else $error("timing set changed mid-frame"); // R9
endmodule

// File: tb/lcd_tgen_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: per-tick reference computed from line/frame position.
module lcd_tgen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_ce = 1'b0;
    logic       enable = 1'b0;
    logic       vs_pol = 1'b0, hs_pol = 1'b0;
    logic [5:0] vs_width_m1 = '0, hs_width_m1 = '0;
    logic [7:0] frame_wait = '0, bol_wait_m1 = '0, eol_wait_m1 = '0;
    logic [9:0] ppl_m1 = '0, lines_m1 = '0;
    logic [7:0] pix_in = '0;
    logic       pix_req, vsync, hsync, oe, pclk;
    logic [7:0] pix_data;

    always #10 clk = ~clk;

    lcd_tgen dut_i (
        .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .enable(enable),
        .vs_pol(vs_pol), .hs_pol(hs_pol), .vs_width_m1(vs_width_m1),
        .hs_width_m1(hs_width_m1), .frame_wait(frame_wait),
        .bol_wait_m1(bol_wait_m1), .eol_wait_m1(eol_wait_m1),
        .ppl_m1(ppl_m1), .lines_m1(lines_m1), .pix_in(pix_in),
        .pix_req(pix_req), .vsync(vsync), .hsync(hsync), .oe(oe),
        .pclk(pclk), .pix_data(pix_data)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    // frame parameters captured by the reference at frame start
    int f_vsw, f_bfw, f_lines, f_hsw, f_blw, f_ppl, f_elw;
    bit f_vp, f_hp;
    int t = -1;            // tick index within frame, -1 = idle
    int div = 1, cyc = 0;
    bit en_next = 0, en_q = 0, ce_q = 0, req_q = 0;
    logic [7:0] pend = '0, exp_data = '0;
    string ctx = "";

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s t=%0d actual=%0d expected=%0d", tag, what, t, act, exp);
        end
    endtask

    function automatic int line_len();
        return f_hsw + f_blw + f_ppl + f_elw;
    endfunction

    function automatic int frame_len();
        return (f_vsw + f_bfw + f_lines) * line_len();
    endfunction

    function automatic int live_frame_len();
        return (int'(vs_width_m1) + 1 + int'(frame_wait) + int'(lines_m1) + 1) *
               (int'(hs_width_m1) + int'(bol_wait_m1) + int'(eol_wait_m1) + int'(ppl_m1) + 4);
    endfunction

    // Expected sync/oe activity at tick tt of the captured frame.
    function automatic void exp_at(input int tt, output bit vs, output bit hs, output bit en);
        int l   = line_len();
        int li  = tt / l;
        int pos = tt % l;
        vs = li < f_vsw;
        hs = pos < f_hsw;
        en = (li >= f_vsw + f_bfw) && (pos >= f_hsw + f_blw) && (pos < f_hsw + f_blw + f_ppl);
    endfunction

    task automatic sample_cfg();
        f_vsw = int'(vs_width_m1) + 1; f_bfw = int'(frame_wait);
        f_lines = int'(lines_m1) + 1;  f_hsw = int'(hs_width_m1) + 1;
        f_blw = int'(bol_wait_m1) + 1; f_ppl = int'(ppl_m1) + 1;
        f_elw = int'(eol_wait_m1) + 1; f_vp = vs_pol; f_hp = hs_pol;
    endtask

    // One clock: update reference, drive inputs, check outputs.
    task automatic tick();
        bit vs, hs, en, vs2, hs2, en2, exp_req;
        string tv, th, to;
        @(negedge clk);
        if (ce_q) begin
            if (!en_q) t = -1;
            else if (t == -1 || t == frame_len() - 1) begin t = 0; sample_cfg(); end
            else t++;
            if (req_q) exp_data = pend;
        end
        enable = en_next;
        pix_ce = (cyc % div) == 0;
        cyc++;
        pix_in = 8'($urandom);
        #1;
        if (t == -1) begin
            vs = 0; hs = 0; en = 0;
            tv = "R1"; th = "R1"; to = "R1";
            chk(vs_pol ? "R2" : "R1", "idle vsync", int'(vsync), int'(vs_pol));
            chk(hs_pol ? "R2" : "R1", "idle hsync", int'(hsync), int'(hs_pol));
        end else begin
            exp_at(t, vs, hs, en);
            tv = f_vp ? "R2" : "R5";
            th = f_hp ? "R2" : "R3";
            to = ((t / line_len()) < f_vsw + f_bfw) ? "R6" : "R4";
            if (!ce_q) begin tv = "R10"; th = "R10"; to = "R10"; end
            if (ctx != "") begin tv = ctx; th = ctx; to = ctx; end
            chk(tv, "vsync", int'(vsync), int'(vs ^ f_vp));
            chk(th, "hsync", int'(hsync), int'(hs ^ f_hp));
        end
        chk(to, "oe", int'(oe), int'(en));
        chk("R7", "pclk", int'(pclk), int'(en && pix_ce));
        chk("R8", "pix_data", int'(pix_data), en ? int'(exp_data) : 0);
        exp_req = 0;
        if (pix_ce && enable && t != -1 && t != frame_len() - 1) begin
            exp_at(t + 1, vs2, hs2, en2);
            exp_req = en2;
        end
        chk("R8", "pix_req", int'(pix_req), int'(exp_req));
        en_q = enable; ce_q = pix_ce; req_q = exp_req; pend = pix_in;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic setcfg(input int vsw, input int bfw, input int ln, input int hsw,
                          input int blw, input int ppl, input int elw, input bit vp, input bit hp);
        vs_width_m1 = 6'(vsw - 1); frame_wait = 8'(bfw); lines_m1 = 10'(ln - 1);
        hs_width_m1 = 6'(hsw - 1); bol_wait_m1 = 8'(blw - 1); ppl_m1 = 10'(ppl - 1);
        eol_wait_m1 = 8'(elw - 1); vs_pol = vp; hs_pol = hp;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #4000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        int fl;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: idle after reset
        run(6);
        // R3 R4 R5 R6: directed frame, 16 pixels
        setcfg(1, 2, 2, 4, 1, 16, 1, 0, 0); div = 1; en_next = 1;
        run(2 * live_frame_len() + 10);
        // R2: inverted polarities, then idle levels with pol=1
        setcfg(2, 1, 2, 2, 2, 3, 2, 1, 1); div = 2;
        run(2 * 2 * live_frame_len() + 20);
        en_next = 0; run(8);
        // R6: zero frame wait
        setcfg(2, 0, 2, 1, 1, 1, 1, 0, 1); en_next = 1; div = 1;
        run(2 * live_frame_len() + 10);
        // R4: widest line
        en_next = 0; run(4);
        setcfg(1, 0, 2, 64, 256, 1024, 256, 0, 0); en_next = 1;
        run(live_frame_len() + 40);
        // R6: longest frame wait
        en_next = 0; run(4);
        setcfg(1, 255, 1, 1, 1, 2, 1, 1, 0); en_next = 1;
        run(live_frame_len() + 20);
        // R5: widest frame sync
        en_next = 0; run(4);
        setcfg(64, 1, 1, 1, 1, 1, 1, 0, 0); en_next = 1; div = 2;
        run(2 * live_frame_len() + 20);
        // R9: change fields mid-frame
        en_next = 0; run(4);
        setcfg(1, 1, 2, 2, 2, 4, 2, 0, 0); en_next = 1; div = 1;
        fl = live_frame_len();
        run(fl / 2);
        ctx = "R9";
        setcfg(2, 0, 1, 1, 3, 5, 1, 1, 1);
        run(fl / 2 + 2 * live_frame_len() + 10);
        ctx = "";
        // R1: disable mid-line, stays idle, then restart
        run(7); en_next = 0; run(10);
        en_next = 1; run(live_frame_len() + 5);
        // random configurations and pixel rates
        for (int k = 0; k < 12; k++) begin
            setcfg(1 + int'($urandom % 3), int'($urandom % 3), 1 + int'($urandom % 3),
                   1 + int'($urandom % 4), 1 + int'($urandom % 4), 1 + int'($urandom % 8),
                   1 + int'($urandom % 4), 1'($urandom), 1'($urandom));
            div = 1 + int'($urandom % 3);
            run((2 * live_frame_len() + 6) * div);
        end
        en_next = 0; run(6);
        summary();
    end
endmodule